// File: doc/BRIEF.md
# Indirect Interrupt-File Register Router

This block sits between a hart's indirect register port and a bank of interrupt files. Each file holds a delivery-enable bit, a priority threshold, one pending bit per interrupt identity and one enable bit per identity. An access carries the requester's privilege, a virtualization flag, a guest-file select, an 8-bit register select, an access width (32 or 64 bits), write data and a per-bit write mask. The block picks the target file, routes the access to the right register, returns the value held before the access, and applies the masked write in the same step.

The pending and enable arrays are reached a word at a time, through windows whose layout depends on the access width. The identity-0 bit cannot be set. A separate select input reaches the top-interrupt register. Reading it returns the identity that an external priority search reports for the target file. Writing it with any mask bit set clears that identity's pending bit. A request lasts one cycle, and its response (valid, data, error) appears on the following cycle.

Top module: `icsr_router`

## Requirements
- R1: After reset, no response is valid, and every delivery bit, threshold, pending bit and enable bit of every file reads as zero.
- R2: A request in cycle N gives `rsp_valid_o` high in cycle N+1 only, with `rdata_o` and `err_o` valid in that cycle; without a request `rsp_valid_o` stays low.
- R3: In a supervisor instance (`MACHINE`=0), only privilege code 1 is legal. With `virt_i`=0 the access targets file 0. With `virt_i`=1 it targets file `gsel_i`, which must be nonzero and below `NFILES`. Every other combination returns an error.
- R4: In a machine instance (`MACHINE`=1), only privilege code 3 with `virt_i`=0 is legal, and it targets file 0. Every other combination returns an error.
- R5: Select 0x70 reaches the delivery-enable bit, which is data bit 0. Select 0x72 reaches the threshold, which is data bits 10:0. All other bits read as zero.
- R6: An access returns the old register value. Each bit whose mask bit is 1 then takes the data bit, and each bit whose mask bit is 0 keeps its value.
- R7: In a 32-bit access (`wide_i`=0), pending select 0x80+k reaches identities 32k to 32k+31 on data bits 31:0. Bits 63:32 read as zero, and mask bits 63:32 are ignored. k at or above `NIDS`/32 is an error.
- R8: In a 64-bit access (`wide_i`=1), an odd k is an error. Otherwise word k/2 reaches identities 64(k/2) to 64(k/2)+63, and a word number at or above `NIDS`/64 is an error.
- R9: Selects 0xC0+k reach the enable array, with the same windowing as the pending array.
- R10: The bit of identity 0 in both the pending and the enable array reads as zero and ignores writes.
- R11: A select other than 0x70, 0x72 or 0x80 to 0xFF, with `top_sel_i` low, is an error and changes no state.
- R12: With `top_sel_i` high, `rsel_i` is ignored. The read returns the target file's identity from `top_ids_i` (file f at bits f*IDW upward) in bits 15:0 and again in bits 31:16. If that identity is nonzero and any mask bit within the access width is set, its pending bit is cleared.
- R13: An error response returns all-zero read data and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Single-cycle access request |
| priv_i | input | 2 | Requester privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization flag |
| gsel_i | input | GSW | Guest file select |
| rsel_i | input | 8 | Register select |
| top_sel_i | input | 1 | Access the top-interrupt register instead of `rsel_i` |
| wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wdata_i | input | 64 | Write data |
| wmask_i | input | 64 | Per-bit write mask |
| top_ids_i | input | NFILES*IDW | Top identity per file from the external search |
| rsp_valid_o | output | 1 | Response valid |
| rdata_o | output | 64 | Value before the access |
| err_o | output | 1 | Access was illegal |

## Verification
The assertions check, on every cycle, the timing link between request and response, and the fixed facts of each response: a user-privilege request always errors, an unknown select always errors, error data is zero, the upper half of a 32-bit response is zero, and the identity-0 bit of word 0 is never seen set. Whether the right file and the right window were hit, whether masked writes merged correctly, and whether a top-register write cleared the right pending bit depend on stored state. Only the bench's scenarios show these, by comparing each response against a behavioural model that replays every access.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_DELIV,
        KIND_THRESH,
        KIND_TOP,
        KIND_PEND,
        KIND_EN
    } reg_kind_e;

    localparam logic [7:0] SEL_DELIV  = 8'h70;
    localparam logic [7:0] SEL_THRESH = 8'h72;

    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/icsr_file_pick.sv
module icsr_file_pick #(
    parameter bit MACHINE = 1'b0,
    parameter int NFILES  = 4,
    parameter int GSW     = 6,
    localparam int FW     = (NFILES > 1) ? $clog2(NFILES) : 1
) (
    input  logic [1:0]     priv_i,
    input  logic           virt_i,
    input  logic [GSW-1:0] gsel_i,
    output logic [FW-1:0]  file_o,
    output logic           ok_o
);
    import icsr_pkg::*;

    generate
        if (MACHINE) begin : g_mach
            always_comb begin
                file_o = '0;
                ok_o   = (priv_i == PRIV_M) && !virt_i;
            end
        end else begin : g_sup
            always_comb begin
                file_o = '0;
                ok_o   = 1'b0;
                if (priv_i == PRIV_S) begin
                    if (!virt_i) begin
                        ok_o = 1'b1;
                    end else if ((gsel_i != '0) && (32'(gsel_i) < 32'(NFILES))) begin
                        ok_o   = 1'b1;
                        file_o = FW'(gsel_i);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/icsr_sel_decode.sv
module icsr_sel_decode #(
    parameter int NIDS = 64,
    localparam int IDW = $clog2(NIDS)
) (
    input  logic [7:0]          rsel_i,
    input  logic                top_sel_i,
    input  logic                wide_i,
    output icsr_pkg::reg_kind_e kind_o,
    output logic                word_ok_o,
    output logic [IDW-1:0]      base_o
);
    import icsr_pkg::*;

    localparam int NW32 = NIDS / 32;
    localparam int NW64 = NIDS / 64;

    logic [5:0] k;
    logic [5:0] word;

    always_comb begin
        k    = rsel_i[5:0];
        word = wide_i ? {1'b0, k[5:1]} : k;

        if (top_sel_i)                 kind_o = KIND_TOP;
        else if (rsel_i == SEL_DELIV)  kind_o = KIND_DELIV;
        else if (rsel_i == SEL_THRESH) kind_o = KIND_THRESH;
        else if (rsel_i[7:6] == 2'b10) kind_o = KIND_PEND;
        else if (rsel_i[7:6] == 2'b11) kind_o = KIND_EN;
        else                           kind_o = KIND_NONE;

        if (wide_i) word_ok_o = !k[0] && (32'(word) < 32'(NW64));
        else        word_ok_o = 32'(word) < 32'(NW32);

        base_o = wide_i ? IDW'(32'(word) * 64) : IDW'(32'(word) * 32);
    end

endmodule

// File: rtl/icsr_router.sv
module icsr_router #(
    parameter bit MACHINE = 1'b0,
    parameter int NFILES  = 4,
    parameter int NIDS    = 64,
    parameter int GSW     = 6,
    parameter int THR_W   = 11,
    localparam int IDW    = $clog2(NIDS),
    localparam int FW     = (NFILES > 1) ? $clog2(NFILES) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_i,
    input  logic [1:0]            priv_i,
    input  logic                  virt_i,
    input  logic [GSW-1:0]        gsel_i,
    input  logic [7:0]            rsel_i,
    input  logic                  top_sel_i,
    input  logic                  wide_i,
    input  logic [63:0]           wdata_i,
    input  logic [63:0]           wmask_i,
    input  logic [NFILES*IDW-1:0] top_ids_i,
    output logic                  rsp_valid_o,
    output logic [63:0]           rdata_o,
    output logic                  err_o
);
    import icsr_pkg::*;

    localparam int TOP_SHIFT = 16;

    typedef struct packed {
        logic [NFILES-1:0]             deliv;
        logic [NFILES-1:0][THR_W-1:0]  thr;
        logic [NFILES-1:0][NIDS-1:0]   pend;
        logic [NFILES-1:0][NIDS-1:0]   en;
        logic                          rsp_valid;
        logic                          rsp_err;
        logic [63:0]                   rdata;
    } state_t;

    state_t s_d, s_q;

    logic [FW-1:0]  file;
    logic           file_ok;
    reg_kind_e      kind;
    logic           word_ok;
    logic [IDW-1:0] base;

    icsr_file_pick #(
        .MACHINE (MACHINE),
        .NFILES  (NFILES),
        .GSW     (GSW)
    ) file_pick_i (
        .priv_i (priv_i),
        .virt_i (virt_i),
        .gsel_i (gsel_i),
        .file_o (file),
        .ok_o   (file_ok)
    );

    icsr_sel_decode #(
        .NIDS (NIDS)
    ) sel_decode_i (
        .rsel_i    (rsel_i),
        .top_sel_i (top_sel_i),
        .wide_i    (wide_i),
        .kind_o    (kind),
        .word_ok_o (word_ok),
        .base_o    (base)
    );

    logic [63:0]    mask_eff;
    logic [IDW-1:0] top_id;
    logic           is_array;
    logic           illegal;
    logic [IDW-1:0] bit_idx;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_i;
        s_d.rsp_err   = 1'b0;
        s_d.rdata     = '0;

        mask_eff = wide_i ? wmask_i : {32'd0, wmask_i[31:0]};
        top_id   = top_ids_i[32'(file) * IDW +: IDW];
        is_array = (kind == KIND_PEND) || (kind == KIND_EN);
        illegal  = !file_ok || (kind == KIND_NONE) || (is_array && !word_ok);
        bit_idx  = '0;

        if (req_i) begin
            if (illegal) begin
                s_d.rsp_err = 1'b1;
            end else begin
                unique case (kind)
                    KIND_DELIV: begin
                        s_d.rdata[0] = s_q.deliv[file];
                        if (mask_eff[0]) s_d.deliv[file] = wdata_i[0];
                    end
                    KIND_THRESH: begin
                        s_d.rdata[THR_W-1:0] = s_q.thr[file];
                        s_d.thr[file] = (s_q.thr[file] & ~mask_eff[THR_W-1:0])
                                      | (wdata_i[THR_W-1:0] & mask_eff[THR_W-1:0]);
                    end
                    KIND_TOP: begin
                        s_d.rdata = 64'(top_id) | (64'(top_id) << TOP_SHIFT);
                        if ((top_id != '0) && (mask_eff != '0)) begin
                            s_d.pend[file][top_id] = 1'b0;
                        end
                    end
                    KIND_PEND, KIND_EN: begin
                        for (int i = 0; i < 64; i++) begin
                            if (wide_i || (i < 32)) begin
                                bit_idx = IDW'(32'(base) + i);
                                if (kind == KIND_PEND) begin
                                    s_d.rdata[i] = s_q.pend[file][bit_idx];
                                    if (mask_eff[i] && (bit_idx != '0))
                                        s_d.pend[file][bit_idx] = wdata_i[i];
                                end else begin
                                    s_d.rdata[i] = s_q.en[file][bit_idx];
                                    if (mask_eff[i] && (bit_idx != '0))
                                        s_d.en[file][bit_idx] = wdata_i[i];
                                end
                            end
                        end
                    end
                    default: s_d.rsp_err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rsp_valid_o = s_q.rsp_valid;
    assign rdata_o     = s_q.rdata;
    assign err_o       = s_q.rsp_err;

endmodule

// File: rtl/icsr_router_chk.sv
module icsr_router_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_i,
    input logic [1:0]  priv_i,
    input logic [7:0]  rsel_i,
    input logic        top_sel_i,
    input logic        wide_i,
    input logic        rsp_valid_o,
    input logic [63:0] rdata_o,
    input logic        err_o
);
    logic sel_unknown;
    assign sel_unknown = !top_sel_i && (rsel_i != 8'h70) && (rsel_i != 8'h72) && !rsel_i[7];

    assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_valid_o);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rsp_valid_o);

    assert_user_priv_rejected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && (priv_i == 2'd0)) |=> err_o);

    assert_unknown_sel_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && sel_unknown) |=> err_o);

    assert_err_data_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && err_o) |-> (rdata_o == 64'd0));

    assert_narrow_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !wide_i) |=> (rdata_o[63:32] == 32'd0));

    assert_id0_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !top_sel_i && ((rsel_i == 8'h80) || (rsel_i == 8'hC0))) |=> !rdata_o[0]);

endmodule

bind icsr_router icsr_router_chk chk_i (.*);

// File: tb/icsr_router_tb_top.sv
`timescale 1ns/1ps
module icsr_router_tb_top;

    localparam int NF  = 4;
    localparam int NI  = 64;
    localparam int IDW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  priv = 2'd0;
    logic        virt = 1'b0;
    logic [5:0]  gsel = '0;
    logic [7:0]  rsel = '0;
    logic        tsel = 1'b0;
    logic        wide = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] wmask = '0;
    logic [NF*IDW-1:0] top_ids = '0;

    logic        rv, re, mrv, mre;
    logic [63:0] rd, mrd;

    always #2 clk = ~clk;

    icsr_router #(.MACHINE(1'b0), .NFILES(NF), .NIDS(NI)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .priv_i(priv), .virt_i(virt),
        .gsel_i(gsel), .rsel_i(rsel), .top_sel_i(tsel), .wide_i(wide),
        .wdata_i(wdata), .wmask_i(wmask), .top_ids_i(top_ids),
        .rsp_valid_o(rv), .rdata_o(rd), .err_o(re));

    icsr_router #(.MACHINE(1'b1), .NFILES(1), .NIDS(NI)) dut_m_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .priv_i(priv), .virt_i(virt),
        .gsel_i(gsel), .rsel_i(rsel), .top_sel_i(tsel), .wide_i(wide),
        .wdata_i(wdata), .wmask_i(wmask), .top_ids_i(top_ids[IDW-1:0]),
        .rsp_valid_o(mrv), .rdata_o(mrd), .err_o(mre));

    int checks = 0;
    int fails  = 0;

    bit         pend_m [NF][NI];
    bit         en_m   [NF][NI];
    bit         dl_m   [NF];
    logic [10:0] thr_m [NF];

    logic        exp_v = 1'b0, exp_e = 1'b0, mexp_v = 1'b0, mexp_e = 1'b0;
    logic [63:0] exp_d = '0;
    string       rsp_tag = "R1";

    task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    function automatic bit sel_err(logic [7:0] rs, logic ts, logic wd);
        int k;
        if (ts) return 1'b0;
        if (rs == 8'h70 || rs == 8'h72) return 1'b0;
        if (rs < 8'h80) return 1'b1;
        k = int'(rs) % 64;
        if (wd) return (k % 2 == 1) || ((k / 2) >= NI / 64);
        return k >= NI / 32;
    endfunction

    task automatic model_update();
        bit ok;
        int f, id, k, w, base, n;
        logic [63:0] m;
        exp_v = req; mexp_v = req;
        exp_e = 1'b0; mexp_e = 1'b0; exp_d = '0;
        if (!req) return;
        mexp_e = !(priv == 2'd3 && !virt) || sel_err(rsel, tsel, wide);
        ok = (priv == 2'd1);
        f = 0;
        if (ok && virt) begin
            if (gsel != 0 && int'(gsel) < NF) f = int'(gsel);
            else ok = 1'b0;
        end
        if (!ok || sel_err(rsel, tsel, wide)) begin
            exp_e = 1'b1;
            return;
        end
        m = wide ? wmask : (wmask & 64'h0000_0000_FFFF_FFFF);
        if (tsel) begin
            id = int'(top_ids[f*IDW +: IDW]);
            exp_d = 64'(id) | (64'(id) << 16);
            if (id != 0 && m != 0) pend_m[f][id] = 1'b0;
        end else if (rsel == 8'h70) begin
            exp_d = 64'(dl_m[f]);
            if (m[0]) dl_m[f] = wdata[0];
        end else if (rsel == 8'h72) begin
            exp_d = 64'(thr_m[f]);
            for (int b = 0; b < 11; b++) if (m[b]) thr_m[f][b] = wdata[b];
        end else begin
            k = int'(rsel) % 64;
            w = wide ? k / 2 : k;
            n = wide ? 64 : 32;
            base = w * n;
            for (int i = 0; i < n; i++) begin
                if (rsel < 8'hC0) begin
                    exp_d[i] = pend_m[f][base+i];
                    if (m[i] && (base + i) != 0) pend_m[f][base+i] = wdata[i];
                end else begin
                    exp_d[i] = en_m[f][base+i];
                    if (m[i] && (base + i) != 0) en_m[f][base+i] = wdata[i];
                end
            end
        end
    endtask

    task automatic step(string t, logic rq, logic [1:0] pv, logic vt, logic [5:0] gs,
                        logic [7:0] rs, logic ts, logic wd, logic [63:0] d, logic [63:0] m);
        @(negedge clk);
        chk(rsp_tag, "rsp_valid", 64'(rv), 64'(exp_v));
        chk(rsp_tag, "err", 64'(re), 64'(exp_e));
        chk(rsp_tag, "rdata", rd, exp_d);
        chk("R4", "mach_valid", 64'(mrv), 64'(mexp_v));
        chk("R4", "mach_err", 64'(mre), 64'(mexp_e));
        rsp_tag = t;
        req = rq; priv = pv; virt = vt; gsel = gs; rsel = rs;
        tsel = ts; wide = wd; wdata = d; wmask = m;
        model_update();
    endtask

    task automatic idle(string t);
        step(t, 1'b0, 2'd0, 1'b0, 6'd0, 8'h00, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic rdr(string t, logic vt, logic [5:0] gs, logic [7:0] rs, logic wd);
        step(t, 1'b1, 2'd1, vt, gs, rs, 1'b0, wd, '0, '0);
    endtask

    task automatic wrr(string t, logic vt, logic [5:0] gs, logic [7:0] rs, logic wd,
                       logic [63:0] d, logic [63:0] m);
        step(t, 1'b1, 2'd1, vt, gs, rs, 1'b0, wd, d, m);
    endtask

    localparam logic [63:0] ONES = '1;

    initial begin
        for (int f = 0; f < NF; f++) begin
            dl_m[f] = 1'b0; thr_m[f] = '0;
            for (int i = 0; i < NI; i++) begin pend_m[f][i] = 1'b0; en_m[f][i] = 1'b0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle("R1"); idle("R1");
        rdr("R1", 0, 0, 8'h70, 0); rdr("R1", 0, 0, 8'h72, 0);
        rdr("R1", 0, 0, 8'h80, 1); rdr("R1", 0, 0, 8'hC0, 1);

        // R5 / R6: delivery and threshold, masked merge
        wrr("R5", 0, 0, 8'h70, 1, ONES, ONES);
        rdr("R5", 0, 0, 8'h70, 1);
        wrr("R6", 0, 0, 8'h70, 1, '0, '0);
        rdr("R6", 0, 0, 8'h70, 1);
        wrr("R5", 0, 0, 8'h72, 0, 64'hFFFF, 64'hFFFF);
        rdr("R5", 0, 0, 8'h72, 0);
        wrr("R6", 0, 0, 8'h72, 0, 64'h0, 64'h0F0);
        rdr("R6", 0, 0, 8'h72, 0);

        // R7 / R10: narrow pending windows, identity 0 hardwired
        wrr("R10", 0, 0, 8'h80, 0, ONES, ONES);
        rdr("R10", 0, 0, 8'h80, 0);
        rdr("R7", 0, 0, 8'h81, 0);
        wrr("R7", 0, 0, 8'h81, 0, 64'hFFFF_FFFF_A5A5_A5A5, ONES);
        rdr("R7", 0, 0, 8'h80, 1);
        rdr("R7", 0, 0, 8'h82, 0);

        // R8: wide windows
        rdr("R8", 0, 0, 8'h81, 1);
        rdr("R8", 0, 0, 8'h82, 1);
        wrr("R8", 0, 0, 8'h80, 1, 64'h1234_5678_9ABC_DEF1, 64'hFFFF_0000_0000_FFFF);
        rdr("R8", 0, 0, 8'h80, 1);

        // R9: enable array
        wrr("R9", 0, 0, 8'hC0, 1, ONES, ONES);
        rdr("R9", 0, 0, 8'hC0, 1);
        wrr("R9", 0, 0, 8'hC1, 0, 64'h0, 64'h0000_0000_0F0F_0000);
        rdr("R9", 0, 0, 8'hC1, 0);
        rdr("R9", 0, 0, 8'hC3, 0);
        rdr("R10", 0, 0, 8'hC0, 0);

        // R3: file selection
        wrr("R3", 1, 2, 8'h70, 0, 64'h1, 64'h1);
        wrr("R3", 0, 0, 8'h70, 0, 64'h0, 64'h1);
        rdr("R3", 1, 2, 8'h70, 0);
        rdr("R3", 0, 0, 8'h70, 0);
        rdr("R3", 1, 0, 8'h70, 0);
        rdr("R3", 1, 4, 8'h70, 0);
        rdr("R3", 1, 3, 8'h70, 0);
        step("R3", 1'b1, 2'd3, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, '0, '0);
        step("R3", 1'b1, 2'd0, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, ONES, ONES);
        step("R3", 1'b1, 2'd2, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, '0, '0);

        // R4: machine instance (checked on dut_m_i every cycle)
        step("R4", 1'b1, 2'd3, 1'b0, 6'd0, 8'h72, 1'b0, 1'b0, 64'h5, ONES);
        step("R4", 1'b1, 2'd3, 1'b1, 6'd1, 8'h72, 1'b0, 1'b0, '0, '0);
        step("R4", 1'b1, 2'd3, 1'b0, 6'd0, 8'h83, 1'b0, 1'b1, '0, '0);

        // R11 / R13: unknown selects change nothing
        wrr("R11", 0, 0, 8'h71, 0, ONES, ONES);
        wrr("R11", 0, 0, 8'h00, 0, ONES, ONES);
        wrr("R13", 0, 0, 8'h7F, 0, '0, ONES);
        rdr("R11", 0, 0, 8'h70, 0);
        rdr("R11", 0, 0, 8'h72, 0);

        // R12: top-interrupt register
        top_ids = {6'd0, 6'd9, 6'd5, 6'd0};
        wrr("R12", 1, 1, 8'h80, 0, 64'h0000_0220, ONES);
        step("R12", 1'b1, 2'd1, 1'b1, 6'd1, 8'h70, 1'b1, 1'b0, '0, '0);
        step("R12", 1'b1, 2'd1, 1'b1, 6'd1, 8'h70, 1'b1, 1'b0, '0, 64'hFFFF_FFFF_0000_0000);
        rdr("R12", 1, 1, 8'h80, 0);
        step("R12", 1'b1, 2'd1, 1'b1, 6'd1, 8'h00, 1'b1, 1'b0, '0, 64'h1);
        rdr("R12", 1, 1, 8'h80, 0);
        step("R12", 1'b1, 2'd1, 1'b0, 6'd0, 8'h80, 1'b1, 1'b1, '0, ONES);
        rdr("R12", 0, 0, 8'h80, 1);
        step("R12", 1'b1, 2'd1, 1'b1, 6'd2, 8'h72, 1'b1, 1'b1, '0, '0);

        // R2: response stops when requests stop
        idle("R2"); idle("R2"); idle("R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule